// File: doc/BRIEF.md
# Load/Store Address Generator

This unit sits between instruction issue and a simple synchronous memory port. It accepts one 32-bit instruction word at a time and decodes it. Using the values from two combinational register-file read ports, it forms the effective address of an integer or floating-point load or store. It then issues the access as one or more 32-bit word beats. Integer accesses are byte, halfword or word wide. Floating-point accesses move one, two or four consecutive words.

The access size is encoded in the low bits of the offset field, and those bits are cleared before the offset is added. Integer stores build their 16-bit offset from two separated instruction fields, so that the data register can occupy the middle field. Load data is lane-selected, sign-extended where required, and returned with an integer or floating-point destination index. FP stores read their data one word per beat through a dedicated FP read port. An FP auto-increment request writes the effective address back to the base register one cycle after acceptance.

Top module: `lsag_top`

## Requirements
- R1: `instr_ready` is high only when no access is in progress. An instruction is taken on a clock edge with `instr_valid` and `instr_ready` both high. From the next cycle, `instr_ready` stays low until the edge at which the last beat completes. An opcode outside 0x00, 0x01, 0x03, 0x04, 0x05, 0x07 and 0x08–0x0B (opcode = bits 31:26) is taken without any memory request or writeback.
- R2: Opcodes 0x00 and 0x01 are byte loads. The address is src2 + src1 for 0x00 and src2 + sign-extended bits 15:0 for 0x01, where src2 = bits 25:21 and src1 = bits 15:11.
- R3: Opcodes 0x04 (src2 + src1) and 0x05 (src2 + immediate) load a word when bit 0 = 1 and a halfword when bit 0 = 0. The immediate has bits 1:0 cleared for a word and bit 0 cleared for a halfword.
- R4: An integer load returns data in the cycle its beat completes, with `ld_fp` = 0 and `ld_idx` = bits 20:16. A byte is taken from lane ea[1:0] and a halfword from lanes {ea[1],0} and {ea[1],1}. Both are sign-extended to 32 bits. A word is returned unchanged.
- R5: Opcode 0x03 is a byte store and 0x07 a halfword (offset bit 0 = 0) or word (offset bit 0 = 1) store. The offset is {bits 20:16, bits 10:0}, sign-extended, with the size bits cleared as in R3. The data comes from register bits 15:11. Only the addressed byte lanes of `mem_be` are set, and the data appears in those lanes.
- R6: For FP opcodes 0x08–0x0B, bit 1 = 1 selects one word (offset bits 1:0 cleared). Otherwise bit 2 = 1 selects four words (bits 3:0 cleared), else two words (bits 2:0 cleared). Odd opcodes add the immediate to src2.
- R7: Even FP opcodes (0x08, 0x0A) use src2 + src1 as the address, and the immediate is ignored.
- R8: For an FP access with bit 0 = 1, `wb_valid` pulses in the cycle after acceptance with `wb_idx` = src2 and `wb_data` = effective address. No integer access and no FP access with bit 0 = 0 produces a writeback.
- R9: FP loads (0x08, 0x09) issue beat k at ea + 4k. Each beat returns the full word with `ld_fp` = 1 and `ld_idx` = (bits 20:16 aligned down to the word count) + k.
- R10: FP stores (0x0A, 0x0B) issue beat k at ea + 4k with all four byte enables set. They drive `fp_rd_idx` = aligned bits 20:16 + k and write `fp_rd_data`.
- R11: Each beat holds `mem_req` with a steady address, direction and byte enables until `mem_ready` is seen high at a clock edge.
- R12: After reset the unit is idle: `instr_ready` high and `mem_req`, `ld_valid` and `wb_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_word | input | 32 | Instruction word |
| instr_ready | output | 1 | Unit idle, instruction taken this edge if valid |
| rf_a_idx | output | 5 | Integer read index, base register |
| rf_a_data | input | 32 | Base register value |
| rf_b_idx | output | 5 | Integer read index, index or store data register |
| rf_b_data | input | 32 | Index or store data value |
| fp_rd_idx | output | 5 | FP read index for the current store beat |
| fp_rd_data | input | 32 | FP register word for the current store beat |
| mem_req | output | 1 | Beat request |
| mem_we | output | 1 | 1 = write beat |
| mem_addr | output | 32 | Byte address of the beat |
| mem_be | output | 4 | Byte-lane enables, lane i = bits 8i+7:8i |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Beat completes at this edge |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| ld_valid | output | 1 | Load word returned |
| ld_fp | output | 1 | 1 = FP destination |
| ld_idx | output | 5 | Destination register index |
| ld_data | output | 32 | Lane-selected, extended load data |
| wb_valid | output | 1 | Base-register update |
| wb_idx | output | 5 | Base register index |
| wb_data | output | 32 | New base value |

## Verification
The bench targets the decode corners that are easiest to get wrong. If the split store offset is assembled from the wrong fields, stores land at a distant address. If the size flag is not cleared from the offset, addresses are off by one to three bytes. If a halfword or byte is not sign-extended from the correct lane, negative values come back as large positive ones. On the FP side, the bench runs a misaligned destination index for a quad access to check the aligned register sequence and the ea+4k address walk. It runs auto-increment on indexed and immediate forms, and an integer load whose offset has bit 0 set, which must not trigger a writeback. A stalling memory checks that requests are held and that a second instruction waits for the last beat. A design that dropped either rule would issue duplicate or overlapping beats.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
  localparam int XLEN      = 32;
  localparam int RIDX_W    = 5;
  localparam int MAX_WORDS = 4;
  localparam int BEAT_W    = $clog2(MAX_WORDS);
  localparam int OFF_W     = 16;

  localparam logic [5:0] OPC_LDB_X  = 6'h00;
  localparam logic [5:0] OPC_LDB_I  = 6'h01;
  localparam logic [5:0] OPC_STB    = 6'h03;
  localparam logic [5:0] OPC_LDHW_X = 6'h04;
  localparam logic [5:0] OPC_LDHW_I = 6'h05;
  localparam logic [5:0] OPC_STHW   = 6'h07;
  localparam logic [5:0] OPC_FLD_X  = 6'h08;
  localparam logic [5:0] OPC_FLD_I  = 6'h09;
  localparam logic [5:0] OPC_FST_X  = 6'h0A;
  localparam logic [5:0] OPC_FST_I  = 6'h0B;

  typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD} acc_size_e;

  typedef struct packed {
    logic              legal;
    logic              store;
    logic              fp;
    logic              indexed;
    logic              autoinc;
    logic              sext;
    acc_size_e         size;
    logic [BEAT_W-1:0] last_beat;
    logic [OFF_W-1:0]  offset;
    logic [RIDX_W-1:0] data_idx;
    logic [RIDX_W-1:0] base_idx;
    logic [RIDX_W-1:0] index_idx;
  } lsag_op_t;
endpackage

// File: rtl/lsag_decode.sv
module lsag_decode
  import lsag_pkg::*;
(
  input  logic [31:0] instr,
  output lsag_op_t    op
);
  logic [5:0]       opc;
  logic [OFF_W-1:0] imm;
  logic [OFF_W-1:0] soff;

  assign opc  = instr[31:26];
  assign imm  = instr[15:0];
  assign soff = {instr[20:16], instr[10:0]};

  always_comb begin
    op           = '0;
    op.base_idx  = instr[25:21];
    op.index_idx = instr[15:11];
    op.data_idx  = instr[20:16];
    op.size      = SZ_WORD;
    case (opc)
      OPC_LDB_X, OPC_LDB_I: begin
        op.legal   = 1'b1;
        op.indexed = ~opc[0];
        op.size    = SZ_BYTE;
        op.sext    = 1'b1;
        op.offset  = imm;
      end
      OPC_LDHW_X, OPC_LDHW_I: begin
        op.legal   = 1'b1;
        op.indexed = ~opc[0];
        op.size    = instr[0] ? SZ_WORD : SZ_HALF;
        op.sext    = ~instr[0];
        op.offset  = instr[0] ? {imm[15:2], 2'b00} : {imm[15:1], 1'b0};
      end
      OPC_STB: begin
        op.legal    = 1'b1;
        op.store    = 1'b1;
        op.size     = SZ_BYTE;
        op.offset   = soff;
        op.data_idx = instr[15:11];
      end
      OPC_STHW: begin
        op.legal    = 1'b1;
        op.store    = 1'b1;
        op.size     = soff[0] ? SZ_WORD : SZ_HALF;
        op.offset   = soff[0] ? {soff[15:2], 2'b00} : {soff[15:1], 1'b0};
        op.data_idx = instr[15:11];
      end
      OPC_FLD_X, OPC_FLD_I, OPC_FST_X, OPC_FST_I: begin
        op.legal   = 1'b1;
        op.fp      = 1'b1;
        op.store   = opc[1];
        op.indexed = ~opc[0];
        op.autoinc = instr[0];
        op.size    = SZ_WORD;
        if (instr[1]) begin
          op.last_beat = BEAT_W'(0);
          op.offset    = {imm[15:2], 2'b00};
        end else if (instr[2]) begin
          op.last_beat = BEAT_W'(3);
          op.offset    = {imm[15:4], 4'b0000};
        end else begin
          op.last_beat = BEAT_W'(1);
          op.offset    = {imm[15:3], 3'b000};
        end
        op.data_idx = instr[20:16] & ~RIDX_W'(op.last_beat);
      end
      default: op.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsag_lanes.sv
module lsag_lanes
  import lsag_pkg::*;
#(
  parameter  int DATA_W = XLEN,
  localparam int NBYTES = DATA_W / 8,
  localparam int LANE_W = $clog2(NBYTES)
) (
  input  acc_size_e           size,
  input  logic [LANE_W-1:0]   addr_lo,
  input  logic                sext,
  input  logic [DATA_W-1:0]   st_word,
  input  logic [DATA_W-1:0]   ld_word,
  output logic [NBYTES-1:0]   be,
  output logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   ld_val
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    assign be[i] = (size == SZ_BYTE) ? (addr_lo == LANE_W'(i)) :
                   (size == SZ_HALF) ? (addr_lo[LANE_W-1:1] == (LANE_W-1)'(i / 2)) :
                   1'b1;
    assign wdata[8*i +: 8] = (size == SZ_BYTE) ? st_word[7:0] :
                             (size == SZ_HALF) ? st_word[8*(i%2) +: 8] :
                             st_word[8*i +: 8];
  end

  logic [7:0]  ld_b;
  logic [15:0] ld_h;
  assign ld_b = ld_word[8*addr_lo +: 8];
  assign ld_h = ld_word[16*addr_lo[LANE_W-1:1] +: 16];

  always_comb begin
    case (size)
      SZ_BYTE: ld_val = {{(DATA_W-8){sext & ld_b[7]}}, ld_b};
      SZ_HALF: ld_val = {{(DATA_W-16){sext & ld_h[15]}}, ld_h};
      default: ld_val = ld_word;
    endcase
  end
endmodule

// File: rtl/lsag_beats.sv
module lsag_beats #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BEAT_W-1:0] last_in,
  input  logic              mem_ready,
  output logic              busy,
  output logic [BEAT_W-1:0] beat
);
  logic              busy_q, busy_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [BEAT_W-1:0] last_q, last_d;

  always_comb begin
    busy_d = busy_q;
    beat_d = beat_q;
    last_d = last_q;
    if (start) begin
      busy_d = 1'b1;
      beat_d = '0;
      last_d = last_in;
    end else if (busy_q && mem_ready) begin
      if (beat_q == last_q) busy_d = 1'b0;
      else                  beat_d = beat_q + BEAT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= '0;
      last_q <= '0;
    end else begin
      busy_q <= busy_d;
      beat_q <= beat_d;
      last_q <= last_d;
    end
  end

  assign busy = busy_q;
  assign beat = beat_q;
endmodule

// File: rtl/lsag_top.sv
module lsag_top
  import lsag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [31:0]       instr_word,
  output logic              instr_ready,
  output logic [RIDX_W-1:0] rf_a_idx,
  input  logic [XLEN-1:0]   rf_a_data,
  output logic [RIDX_W-1:0] rf_b_idx,
  input  logic [XLEN-1:0]   rf_b_data,
  output logic [RIDX_W-1:0] fp_rd_idx,
  input  logic [XLEN-1:0]   fp_rd_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN/8-1:0] mem_be,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic              mem_ready,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              ld_valid,
  output logic              ld_fp,
  output logic [RIDX_W-1:0] ld_idx,
  output logic [XLEN-1:0]   ld_data,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]   wb_data
);
  localparam int LANE_W = $clog2(XLEN / 8);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // decode and effective address
  lsag_op_t        dec;
  logic [XLEN-1:0] off_ext;
  logic [XLEN-1:0] ea_calc;
  logic            busy;
  logic [BEAT_W-1:0] beat;
  logic            accept;
  logic            start;

  lsag_decode u_dec (
    .instr (instr_word),
    .op    (dec)
  );

  assign rf_a_idx = dec.base_idx;
  assign rf_b_idx = dec.index_idx;
  assign off_ext  = {{(XLEN-OFF_W){dec.offset[OFF_W-1]}}, dec.offset};
  assign ea_calc  = rf_a_data + (dec.indexed ? rf_b_data : off_ext);

  assign instr_ready = ~busy;
  assign accept      = instr_valid & instr_ready;
  assign start       = accept & dec.legal;

  // captured access state
  logic [XLEN-1:0]   ea_q, ea_d;
  logic [XLEN-1:0]   sdata_q, sdata_d;
  logic [RIDX_W-1:0] didx_q, didx_d;
  acc_size_e         size_q, size_d;
  logic              store_q, store_d;
  logic              fp_q, fp_d;
  logic              sext_q, sext_d;
  logic              wbv_q, wbv_d;
  logic [RIDX_W-1:0] wbi_q, wbi_d;
  logic [XLEN-1:0]   wbd_q, wbd_d;

  always_comb begin
    ea_d    = ea_q;
    sdata_d = sdata_q;
    didx_d  = didx_q;
    size_d  = size_q;
    store_d = store_q;
    fp_d    = fp_q;
    sext_d  = sext_q;
    wbi_d   = wbi_q;
    wbd_d   = wbd_q;
    wbv_d   = start & dec.autoinc;
    if (start) begin
      ea_d    = ea_calc;
      sdata_d = rf_b_data;
      didx_d  = dec.data_idx;
      size_d  = dec.size;
      store_d = dec.store;
      fp_d    = dec.fp;
      sext_d  = dec.sext;
      wbi_d   = dec.base_idx;
      wbd_d   = ea_calc;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ea_q    <= '0;
      sdata_q <= '0;
      didx_q  <= '0;
      size_q  <= SZ_WORD;
      store_q <= 1'b0;
      fp_q    <= 1'b0;
      sext_q  <= 1'b0;
      wbv_q   <= 1'b0;
      wbi_q   <= '0;
      wbd_q   <= '0;
    end else begin
      ea_q    <= ea_d;
      sdata_q <= sdata_d;
      didx_q  <= didx_d;
      size_q  <= size_d;
      store_q <= store_d;
      fp_q    <= fp_d;
      sext_q  <= sext_d;
      wbv_q   <= wbv_d;
      wbi_q   <= wbi_d;
      wbd_q   <= wbd_d;
    end
  end

  lsag_beats #(.BEAT_W(BEAT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .last_in   (dec.last_beat),
    .mem_ready (mem_ready),
    .busy      (busy),
    .beat      (beat)
  );

  // beat datapath
  logic [XLEN-1:0]   beat_addr;
  logic [RIDX_W-1:0] beat_idx;
  logic [XLEN-1:0]   st_word;
  logic [XLEN-1:0]   ld_val;

  assign beat_addr = ea_q + {{(XLEN-BEAT_W-2){1'b0}}, beat, 2'b00};
  assign beat_idx  = didx_q | {{(RIDX_W-BEAT_W){1'b0}}, beat};
  assign st_word   = fp_q ? fp_rd_data : sdata_q;

  lsag_lanes #(.DATA_W(XLEN)) u_lanes (
    .size    (size_q),
    .addr_lo (beat_addr[LANE_W-1:0]),
    .sext    (sext_q),
    .st_word (st_word),
    .ld_word (mem_rdata),
    .be      (mem_be),
    .wdata   (mem_wdata),
    .ld_val  (ld_val)
  );

  assign fp_rd_idx = beat_idx;
  assign mem_req   = busy;
  assign mem_we    = store_q;
  assign mem_addr  = beat_addr;

  assign ld_valid  = busy & mem_ready & ~store_q;
  assign ld_fp     = fp_q;
  assign ld_idx    = fp_q ? beat_idx : didx_q;
  assign ld_data   = ld_val;

  assign wb_valid  = wbv_q;
  assign wb_idx    = wbi_q;
  assign wb_data   = wbd_q;
endmodule

// File: rtl/lsag_checker.sv
module lsag_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        instr_valid,
  input logic        instr_ready,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [3:0]  mem_be,
  input logic        mem_ready,
  input logic        wb_valid
);
  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_be)));

  assert_ready_after_beat_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(instr_ready) |-> $past(mem_req && mem_ready));

  assert_lane_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4));

  assert_wb_follows_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(instr_valid && instr_ready));

  assert_beat_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> (!mem_req || (mem_addr == $past(mem_addr) + 32'd4)));
endmodule

bind lsag_top lsag_checker u_lsag_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .instr_ready (instr_ready),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_be      (mem_be),
  .mem_ready   (mem_ready),
  .wb_valid    (wb_valid)
);

// File: tb/tb_lsag_top.sv
module tb_lsag_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic        instr_ready;
  logic [4:0]  rf_a_idx, rf_b_idx, fp_rd_idx;
  logic [31:0] rf_a_data, rf_b_data, fp_rd_data;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        mem_ready = 1'b1;
  logic        ld_valid, ld_fp, wb_valid;
  logic [4:0]  ld_idx, wb_idx;
  logic [31:0] ld_data, wb_data;

  logic [31:0] irf [32];
  logic [31:0] frf [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] memw(input logic [31:0] a);
    return ({a[31:2], 2'b00} * 32'h0123_4567) ^ 32'hC3A5_5A3C;
  endfunction

  assign rf_a_data  = irf[rf_a_idx];
  assign rf_b_data  = irf[rf_b_idx];
  assign fp_rd_data = frf[fp_rd_idx];
  assign mem_rdata  = memw(mem_addr);

  lsag_top dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .instr_ready(instr_ready), .rf_a_idx(rf_a_idx), .rf_a_data(rf_a_data),
    .rf_b_idx(rf_b_idx), .rf_b_data(rf_b_data), .fp_rd_idx(fp_rd_idx),
    .fp_rd_data(fp_rd_data), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .ld_valid(ld_valid), .ld_fp(ld_fp), .ld_idx(ld_idx), .ld_data(ld_data),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model state
  logic [31:0] q_addr[$];
  logic        q_we[$];
  logic [3:0]  q_be[$];
  logic [31:0] q_wd[$];
  string       q_tag[$];
  logic [4:0]  ql_idx[$];
  logic        ql_fp[$];
  logic [31:0] ql_dat[$];
  string       ql_tag[$];
  bit          wb_pend = 0;
  logic [4:0]  wb_eidx;
  logic [31:0] wb_edat;
  bit          run_chk = 0;
  bit          acc_flag = 0;
  bit          stall_mode = 0;
  int          rdy_cnt = 0;

  function automatic logic [31:0] sx16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic push_int(input logic [31:0] ea, input int sz, input bit st,
                          input logic [31:0] d, input logic [4:0] dst, input string tag);
    logic [3:0]  be;
    logic [31:0] wd, rd, lv;
    rd = memw(ea) >> (8 * ea[1:0]);
    if (sz == 1) begin
      be = 4'b0001 << ea[1:0];
      wd = {24'h0, d[7:0]} << (8 * ea[1:0]);
      lv = {{24{rd[7]}}, rd[7:0]};
    end else if (sz == 2) begin
      be = ea[1] ? 4'b1100 : 4'b0011;
      wd = {16'h0, d[15:0]} << (16 * ea[1]);
      rd = memw(ea) >> (16 * ea[1]);
      lv = {{16{rd[15]}}, rd[15:0]};
    end else begin
      be = 4'b1111; wd = d; lv = memw(ea);
    end
    q_addr.push_back(ea); q_we.push_back(st); q_be.push_back(be);
    q_wd.push_back(wd); q_tag.push_back(tag);
    if (!st) begin
      ql_idx.push_back(dst); ql_fp.push_back(1'b0); ql_dat.push_back(lv); ql_tag.push_back("R4");
    end
  endtask

  task automatic model(input logic [31:0] w);
    logic [5:0]  op;
    logic [4:0]  s2, d, s1, db;
    logic [15:0] imm, soff;
    logic [31:0] ea;
    int          words;
    op = w[31:26]; s2 = w[25:21]; d = w[20:16]; s1 = w[15:11];
    imm = w[15:0]; soff = {w[20:16], w[10:0]};
    case (op)
      6'h00: push_int(irf[s2] + irf[s1], 1, 0, 0, d, "R2");
      6'h01: push_int(irf[s2] + sx16(imm), 1, 0, 0, d, "R2");
      6'h04: push_int(irf[s2] + irf[s1], w[0] ? 4 : 2, 0, 0, d, "R3");
      6'h05: push_int(irf[s2] + sx16(w[0] ? (imm & 16'hFFFC) : (imm & 16'hFFFE)),
                      w[0] ? 4 : 2, 0, 0, d, "R3");
      6'h03: push_int(irf[s2] + sx16(soff), 1, 1, irf[s1], d, "R5");
      6'h07: push_int(irf[s2] + sx16(soff[0] ? (soff & 16'hFFFC) : (soff & 16'hFFFE)),
                      soff[0] ? 4 : 2, 1, irf[s1], d, "R5");
      6'h08, 6'h09, 6'h0A, 6'h0B: begin
        words = w[1] ? 1 : (w[2] ? 4 : 2);
        if (op[0]) ea = irf[s2] + sx16(imm & ~16'(words * 4 - 1));
        else       ea = irf[s2] + irf[s1];
        db = d & ~5'(words - 1);
        for (int k = 0; k < words; k++) begin
          q_addr.push_back(ea + 32'(4 * k));
          q_we.push_back(op[1]);
          q_be.push_back(4'b1111);
          q_wd.push_back(frf[db + 5'(k)]);
          q_tag.push_back(op[0] ? (op[1] ? "R10" : "R6") : "R7");
          if (!op[1]) begin
            ql_idx.push_back(db + 5'(k)); ql_fp.push_back(1'b1);
            ql_dat.push_back(memw(ea + 32'(4 * k))); ql_tag.push_back("R9");
          end
        end
        if (w[0]) begin wb_pend = 1; wb_eidx = s2; wb_edat = ea; end
      end
      default: ;
    endcase
  endtask

  // per-cycle comparison, three quarters into the cycle
  always @(negedge clk) begin
    bit exp_ld;
    logic [31:0] m;
    #(CLK_PERIOD/4);
    if (run_chk) begin
      chk(instr_ready == (q_addr.size() == 0), "R1 instr_ready", 32'(instr_ready), 32'(q_addr.size() == 0));
      chk(mem_req == (q_addr.size() != 0), "R11 mem_req", 32'(mem_req), 32'(q_addr.size() != 0));
      chk(wb_valid == wb_pend, "R8 wb_valid", 32'(wb_valid), 32'(wb_pend));
      if (wb_valid && wb_pend) begin
        chk(wb_idx == wb_eidx, "R8 wb_idx", 32'(wb_idx), 32'(wb_eidx));
        chk(wb_data == wb_edat, "R8 wb_data", wb_data, wb_edat);
      end
      wb_pend = 0;
      exp_ld = 0;
      if (mem_req && q_addr.size() != 0) begin
        chk(mem_addr == q_addr[0], {q_tag[0], " mem_addr"}, mem_addr, q_addr[0]);
        chk(mem_we == q_we[0], {q_tag[0], " mem_we"}, 32'(mem_we), 32'(q_we[0]));
        chk(mem_be == q_be[0], {q_tag[0], " mem_be"}, 32'(mem_be), 32'(q_be[0]));
        if (mem_ready) begin
          if (q_we[0]) begin
            m = {{8{mem_be[3]}}, {8{mem_be[2]}}, {8{mem_be[1]}}, {8{mem_be[0]}}};
            chk((mem_wdata & m) == (q_wd[0] & m), {q_tag[0], " mem_wdata"}, mem_wdata & m, q_wd[0] & m);
          end else exp_ld = 1;
          void'(q_addr.pop_front()); void'(q_we.pop_front()); void'(q_be.pop_front());
          void'(q_wd.pop_front()); void'(q_tag.pop_front());
        end
      end
      chk(ld_valid == exp_ld, "R4 ld_valid", 32'(ld_valid), 32'(exp_ld));
      if (ld_valid && exp_ld && ql_idx.size() != 0) begin
        chk(ld_idx == ql_idx[0], {ql_tag[0], " ld_idx"}, 32'(ld_idx), 32'(ql_idx[0]));
        chk(ld_fp == ql_fp[0], {ql_tag[0], " ld_fp"}, 32'(ld_fp), 32'(ql_fp[0]));
        chk(ld_data == ql_dat[0], {ql_tag[0], " ld_data"}, ld_data, ql_dat[0]);
        void'(ql_idx.pop_front()); void'(ql_fp.pop_front());
        void'(ql_dat.pop_front()); void'(ql_tag.pop_front());
      end
      if (instr_valid && instr_ready) begin
        model(instr_word);
        acc_flag = 1;
      end
    end
  end

  always @(negedge clk) begin
    rdy_cnt++;
    mem_ready <= !stall_mode || (rdy_cnt % 3 == 0);
  end

  task automatic issue(input logic [31:0] w);
    instr_valid = 1'b1;
    instr_word  = w;
    do @(negedge clk); while (!acc_flag);
    acc_flag    = 0;
    instr_valid = 1'b0;
  endtask

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] s2,
                                        input logic [4:0] d, input logic [15:0] imm);
    return {op, s2, d, imm};
  endfunction
  function automatic logic [31:0] enc_r(input logic [5:0] op, input logic [4:0] s2,
                                        input logic [4:0] d, input logic [4:0] s1,
                                        input logic [10:0] lo);
    return {op, s2, d, s1, lo};
  endfunction
  function automatic logic [31:0] enc_s(input logic [5:0] op, input logic [4:0] s2,
                                        input logic [4:0] s1, input logic [15:0] off);
    return {op, s2, off[15:11], s1, off[10:0]};
  endfunction

  task automatic program_run();
    issue(enc_i(6'h01, 5'd5, 5'd10, 16'hFFFF));          // R2 imm, bit0 set, no wb
    issue(enc_r(6'h00, 5'd5, 5'd11, 5'd6, 11'h0));       // R2 indexed
    issue(enc_i(6'h05, 5'd7, 5'd12, 16'h0006));          // R3 half
    issue(enc_i(6'h05, 5'd7, 5'd12, 16'h0007));          // R3 word, offset masked
    issue(enc_r(6'h04, 5'd7, 5'd13, 5'd6, 11'h001));     // R3 indexed word
    issue(enc_i(6'h05, 5'd9, 5'd14, 16'hFFF2));          // R3/R4 negative half
    issue(enc_s(6'h03, 5'd7, 5'd9, 16'hFFFD));           // R5 byte store
    issue(enc_s(6'h07, 5'd7, 5'd9, 16'h0102));           // R5 half store
    issue(enc_s(6'h07, 5'd7, 5'd9, 16'h8011));           // R5 word store, split offset
    issue(enc_i(6'h09, 5'd7, 5'd3, 16'h0012));           // R6 single
    issue(enc_i(6'h09, 5'd7, 5'd5, 16'h0028));           // R6/R9 double
    issue(enc_i(6'h09, 5'd8, 5'd7, 16'h0025));           // R8/R9 quad, autoinc
    issue(enc_i(6'h0B, 5'd7, 5'd13, 16'h0044));          // R10 quad store
    issue(enc_r(6'h0A, 5'd7, 5'd2, 5'd6, 11'h001));      // R7/R8 indexed double store
    issue(enc_i(6'h0B, 5'd7, 5'd9, 16'hFFFE));           // R10 single store
    issue(enc_i(6'h10, 5'd7, 5'd9, 16'h1234));           // R1 unknown opcode
    issue(enc_r(6'h08, 5'd8, 5'd1, 5'd6, 11'h7F4));      // R7 indexed load, imm ignored
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      irf[i] = (i == 0) ? 32'h0 : 32'h1000 + 32'(i * 32);
      frf[i] = 32'hF000_0000 | 32'(i * 32'h111);
    end
    irf[5] = 32'h0000_2003;
    irf[6] = 32'h0000_0008;
    irf[9] = 32'h8000_7FFE;
    repeat (3) @(negedge clk);
    // R12: reset state while reset held
    chk(instr_ready == 1'b1, "R12 instr_ready", 32'(instr_ready), 32'h1);
    chk(mem_req == 1'b0, "R12 mem_req", 32'(mem_req), 32'h0);
    chk(ld_valid == 1'b0, "R12 ld_valid", 32'(ld_valid), 32'h0);
    chk(wb_valid == 1'b0, "R12 wb_valid", 32'(wb_valid), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_chk = 1;
    program_run();
    stall_mode = 1;
    program_run();
    for (int t = 0; t < 200 && q_addr.size() != 0; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(q_addr.size() == 0, "R11 beats drained", 32'(q_addr.size()), 32'h0);
    chk(ql_idx.size() == 0, "R9 loads drained", 32'(ql_idx.size()), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  int wd_cycles = 0;
  always @(posedge clk) begin
    wd_cycles++;
    if (wd_cycles > 20000) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog actual=%0d expected=<20000", wd_cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule